// File: doc/BRIEF.md
# Scaled-Index Effective Address Generator

This block turns a memory operand descriptor into a 64-bit effective address. A descriptor names an optional base register, an optional index register, a scale selector and a displacement of one, two or four bytes. The unit holds a sixteen-entry, 64-bit register file that is loaded through a plain write port. It reads the base and index values from that file, scales the index, adds the sign-extended displacement, and returns the sum one cycle later.

Each result is marked with how it is to be used. In address-only mode the sum is a value to write back to the named destination register, and no memory read is flagged. In normal mode the result asks for a memory read at the address. Encodings that are not allowed raise an illegal flag, and such a result asks for neither a read nor a write-back.

Requests enter on a valid/ready stream and results leave on another. A request is accepted in a cycle where both `in_valid` and `in_ready` are high. The output register can take a new result only when it is empty or is being drained in that cycle. While `out_valid` is high and `out_ready` is low, the result is held unchanged and `in_ready` stays low.

Top module: `ea_gen`

## Requirements
- R1: After a synchronous active-high reset, `out_valid` is low and every register in the file reads zero.
- R2: The address is base + (index << scale) + sign-extended displacement, taken modulo 2^64. A scale code of 0, 1, 2 or 3 multiplies the index by 1, 2, 4 or 8.
- R3: A base or an index whose enable bit is low adds zero to the sum, whatever its selector holds.
- R4: The `in_disp_sz` code selects the displacement width: 0 uses `in_disp[7:0]`, 1 uses `in_disp[15:0]` and 2 uses `in_disp[31:0]`. The chosen field is sign-extended, and the bits above it have no effect.
- R5: Either of two encodings is illegal: an enabled index with selector 4, or a `in_disp_sz` code of 3. Such a result has `out_illegal` high, `out_addr` zero, and `out_mem_rd` and `out_wb` both low. Register 4 used as a base is legal.
- R6: A legal request with `in_lea` high gives `out_wb` high and `out_mem_rd` low. A legal request with `in_lea` low gives `out_mem_rd` high and `out_wb` low. `out_dst` repeats the `in_dst` of the request.
- R7: A request accepted at a clock edge shows its result with `out_valid` high from that edge onwards.
- R8: While `out_valid` is high and `out_ready` is low, every output holds its value.
- R9: `in_ready` is high exactly when `out_valid` is low or `out_ready` is high.
- R10: A register write is seen by requests accepted at later edges. A request accepted at the same edge as the write reads the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rf_we | input | 1 | Register file write enable |
| rf_waddr | input | 4 | Register file write index |
| rf_wdata | input | 64 | Register file write value |
| in_valid | input | 1 | Request valid |
| in_ready | output | 1 | Request can be accepted |
| in_base_en | input | 1 | Base term present |
| in_base_sel | input | 4 | Base register number |
| in_idx_en | input | 1 | Index term present |
| in_idx_sel | input | 4 | Index register number |
| in_scale | input | 2 | Index shift amount |
| in_disp | input | 32 | Displacement field |
| in_disp_sz | input | 2 | Displacement width code |
| in_lea | input | 1 | Address-only mode |
| in_dst | input | 4 | Destination register for write-back |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Consumer takes the result |
| out_addr | output | 64 | Effective address |
| out_illegal | output | 1 | Disallowed encoding |
| out_mem_rd | output | 1 | Result requests a memory read |
| out_wb | output | 1 | Result is to be written back to `out_dst` |
| out_dst | output | 4 | Destination register |

## Verification
Every result is due at the first edge after its request is accepted. It is then visible at the following falling edge, and it stays there for as long as `out_ready` is held low. `in_ready` responds within the same cycle to `out_valid` and `out_ready`. The bench keeps a behavioural model that updates at each rising edge, using the same acceptance rule and the register values from before that edge. All outputs are compared with the model one time unit after each falling edge. The directed checks drive a request at a falling edge and sample exactly one falling edge later.

// File: rtl/ea_pkg.sv
package ea_pkg;
  localparam int unsigned XLEN   = 64;
  localparam int unsigned NREG   = 16;
  localparam int unsigned DISPW  = 32;
  localparam int unsigned RSEL_W = $clog2(NREG);
  localparam logic [RSEL_W-1:0] NO_INDEX_REG = RSEL_W'(4);

  typedef enum logic [1:0] {
    DISP_B1  = 2'd0,
    DISP_B2  = 2'd1,
    DISP_B4  = 2'd2,
    DISP_BAD = 2'd3
  } disp_sz_e;
endpackage

// File: rtl/ea_regfile.sv
module ea_regfile
  import ea_pkg::*;
#(
  parameter int unsigned W      = XLEN,
  parameter int unsigned DEPTH  = NREG,
  parameter int unsigned NPORTS = 2,
  localparam int unsigned AW    = $clog2(DEPTH)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 we,
  input  logic [AW-1:0]        waddr,
  input  logic [W-1:0]         wdata,
  input  logic [NPORTS*AW-1:0] raddr,
  output logic [NPORTS*W-1:0]  rdata
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < int'(DEPTH); i++) mem[i] <= '0;
    end else if (we) begin
      mem[waddr] <= wdata;
    end
  end

  // combinational reads see the contents before this edge's write
  for (genvar p = 0; p < int'(NPORTS); p++) begin : g_rd
    assign rdata[p*W +: W] = mem[raddr[p*AW +: AW]];
  end
endmodule

// File: rtl/ea_addr_calc.sv
module ea_addr_calc
  import ea_pkg::*;
#(
  parameter int unsigned W  = XLEN,
  parameter int unsigned DW = DISPW,
  localparam int unsigned AW = RSEL_W
) (
  input  logic [W-1:0]  base_val,
  input  logic          base_en,
  input  logic [W-1:0]  idx_val,
  input  logic          idx_en,
  input  logic [AW-1:0] idx_sel,
  input  logic [1:0]    scale,
  input  logic [DW-1:0] disp,
  input  logic [1:0]    disp_sz,
  output logic [W-1:0]  addr,
  output logic          illegal
);
  logic [W-1:0] base_term, idx_term, disp_ext;

  always_comb begin
    unique case (disp_sz_e'(disp_sz))
      DISP_B1: disp_ext = W'($signed(disp[7:0]));
      DISP_B2: disp_ext = W'($signed(disp[15:0]));
      DISP_B4: disp_ext = W'($signed(disp[31:0]));
      default: disp_ext = '0;
    endcase
  end

  assign base_term = base_en ? base_val : '0;
  assign idx_term  = idx_en ? (idx_val << scale) : '0;
  assign illegal   = (idx_en && idx_sel == NO_INDEX_REG) ||
                     (disp_sz_e'(disp_sz) == DISP_BAD);
  assign addr      = illegal ? '0 : (base_term + idx_term + disp_ext);
endmodule

// File: rtl/ea_gen.sv
module ea_gen
  import ea_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              rf_we,
  input  logic [RSEL_W-1:0] rf_waddr,
  input  logic [XLEN-1:0]   rf_wdata,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              in_base_en,
  input  logic [RSEL_W-1:0] in_base_sel,
  input  logic              in_idx_en,
  input  logic [RSEL_W-1:0] in_idx_sel,
  input  logic [1:0]        in_scale,
  input  logic [DISPW-1:0]  in_disp,
  input  logic [1:0]        in_disp_sz,
  input  logic              in_lea,
  input  logic [RSEL_W-1:0] in_dst,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [XLEN-1:0]   out_addr,
  output logic              out_illegal,
  output logic              out_mem_rd,
  output logic              out_wb,
  output logic [RSEL_W-1:0] out_dst
);
  logic [2*XLEN-1:0]   rd_vals;
  logic [XLEN-1:0]     sum;
  logic                bad;
  logic                accept;
  logic                lea_q;

  ea_regfile #(.W(XLEN), .DEPTH(NREG), .NPORTS(2)) u_rf (
    .clk   (clk),
    .rst   (rst),
    .we    (rf_we),
    .waddr (rf_waddr),
    .wdata (rf_wdata),
    .raddr ({in_idx_sel, in_base_sel}),
    .rdata (rd_vals)
  );

  ea_addr_calc #(.W(XLEN), .DW(DISPW)) u_calc (
    .base_val (rd_vals[0 +: XLEN]),
    .base_en  (in_base_en),
    .idx_val  (rd_vals[XLEN +: XLEN]),
    .idx_en   (in_idx_en),
    .idx_sel  (in_idx_sel),
    .scale    (in_scale),
    .disp     (in_disp),
    .disp_sz  (in_disp_sz),
    .addr     (sum),
    .illegal  (bad)
  );

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
    end else if (accept) begin
      out_valid <= 1'b1;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_addr    <= '0;
      out_illegal <= 1'b0;
      lea_q       <= 1'b0;
      out_dst     <= '0;
    end else if (accept) begin
      out_addr    <= sum;
      out_illegal <= bad;
      lea_q       <= in_lea;
      out_dst     <= in_dst;
    end
  end

  assign out_mem_rd = out_valid && !out_illegal && !lea_q;
  assign out_wb     = out_valid && !out_illegal && lea_q;
endmodule

// File: rtl/ea_gen_chk.sv
module ea_gen_chk
  import ea_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic              in_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic [XLEN-1:0]   out_addr,
  input logic              out_illegal,
  input logic              out_mem_rd,
  input logic              out_wb,
  input logic [RSEL_W-1:0] out_dst
);
  assert_reset_empty_R1: assert property (@(posedge clk) rst |=> !out_valid);

  assert_accept_shows_R7: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> out_valid);

  assert_hold_addr_R8: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_addr) &&
      $stable(out_illegal) && $stable(out_wb) && $stable(out_dst)));

  assert_stall_blocks_R9: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |-> !in_ready);

  assert_illegal_quiet_R5: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_illegal) |-> (!out_mem_rd && !out_wb && out_addr == '0));

  assert_lea_no_read_R6: assert property (@(posedge clk) disable iff (rst)
    !(out_mem_rd && out_wb));
endmodule

bind ea_gen ea_gen_chk u_chk (.*);

// File: tb/tb_ea_gen.sv
module tb_ea_gen;
  logic        clk = 1'b0;
  logic        rst;
  logic        rf_we;
  logic [3:0]  rf_waddr;
  logic [63:0] rf_wdata;
  logic        in_valid, in_ready;
  logic        in_base_en, in_idx_en;
  logic [3:0]  in_base_sel, in_idx_sel, in_dst;
  logic [1:0]  in_scale, in_disp_sz;
  logic [31:0] in_disp;
  logic        in_lea;
  logic        out_valid, out_ready;
  logic [63:0] out_addr;
  logic        out_illegal, out_mem_rd, out_wb;
  logic [3:0]  out_dst;

  int errors = 0;
  int checks = 0;
  int cycles = 0;

  // behavioural reference state
  logic [63:0] m_regs [16];
  logic        m_valid;
  logic [63:0] m_addr;
  logic        m_ill, m_lea;
  logic [3:0]  m_dst;

  always #5 clk = ~clk;

  ea_gen dut (.*);

  function automatic logic [63:0] ref_ea(output logic ill);
    longint signed d;
    logic [63:0] b, x;
    ill = (in_idx_en && in_idx_sel == 4'd4) || in_disp_sz == 2'd3;
    case (in_disp_sz)
      2'd0: d = longint'($signed(in_disp[7:0]));
      2'd1: d = longint'($signed(in_disp[15:0]));
      default: d = longint'($signed(in_disp));
    endcase
    b = in_base_en ? m_regs[in_base_sel] : 64'd0;
    x = in_idx_en ? m_regs[in_idx_sel] * (64'd1 << in_scale) : 64'd0;
    if (ill) return 64'd0;
    return b + x + 64'(d);
  endfunction

  always @(posedge clk) begin
    logic il;
    logic [63:0] a;
    if (rst) begin
      m_valid = 1'b0;
      for (int i = 0; i < 16; i++) m_regs[i] = 64'd0;
    end else begin
      if (in_valid && (!m_valid || out_ready)) begin
        a = ref_ea(il);
        m_valid = 1'b1; m_addr = a; m_ill = il; m_lea = in_lea; m_dst = in_dst;
      end else if (out_ready) begin
        m_valid = 1'b0;
      end
      if (rf_we) m_regs[rf_waddr] = rf_wdata;
    end
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at t=%0t", req, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    #1;
    if (!rst) begin
      chk("R7 out_valid", 64'(out_valid), 64'(m_valid));
      chk("R9 in_ready", 64'(in_ready), 64'(!m_valid || out_ready));
      if (m_valid) begin
        chk("R2 out_addr", out_addr, m_addr);
        chk("R5 out_illegal", 64'(out_illegal), 64'(m_ill));
        chk("R6 out_wb", 64'(out_wb), 64'(!m_ill && m_lea));
        chk("R6 out_mem_rd", 64'(out_mem_rd), 64'(!m_ill && !m_lea));
        chk("R6 out_dst", 64'(out_dst), 64'(m_dst));
      end
    end
  end

  task automatic idle();
    in_valid = 0; rf_we = 0; in_base_en = 0; in_idx_en = 0;
    in_base_sel = 0; in_idx_sel = 0; in_scale = 0; in_disp = 0;
    in_disp_sz = 0; in_lea = 0; in_dst = 0;
  endtask

  task automatic wreg(input int r, input logic [63:0] v);
    @(negedge clk);
    rf_we = 1; rf_waddr = 4'(r); rf_wdata = v;
    @(negedge clk);
    rf_we = 0;
  endtask

  // one request with out_ready high; result sampled one falling edge later
  task automatic req(input string tag, input logic be, input int bs, input logic ie,
                     input int xs, input int sc, input logic [31:0] d, input int dsz,
                     input logic lea, input logic [63:0] exp_a, input logic exp_ill);
    @(negedge clk);
    in_valid = 1; in_base_en = be; in_base_sel = 4'(bs); in_idx_en = ie;
    in_idx_sel = 4'(xs); in_scale = 2'(sc); in_disp = d; in_disp_sz = 2'(dsz);
    in_lea = lea; in_dst = 4'(bs + 3);
    @(negedge clk);
    in_valid = 0;
    #2;
    chk({tag, " valid"}, 64'(out_valid), 64'd1);
    chk({tag, " addr"}, out_addr, exp_a);
    chk({tag, " illegal"}, 64'(out_illegal), 64'(exp_ill));
  endtask

  initial begin
    idle(); out_ready = 1; rf_waddr = 0; rf_wdata = 0;
    rst = 1;
    repeat (3) @(negedge clk);
    rst = 0;
    #2;
    chk("R1 out_valid after reset", 64'(out_valid), 64'd0);

    // R1: file is zero: base+index on r7,r9 gives disp only
    req("R1", 1, 7, 1, 9, 3, 32'h10, 2, 0, 64'h10, 0);
    wreg(1, 64'h1000); wreg(2, 64'd3); wreg(4, 64'hFFFF_FFFF_FFFF_FFF0);
    // R2: 0x1000 + 3*8 + (-1)
    req("R2", 1, 1, 1, 2, 3, 32'h0000_00FF, 0, 0, 64'h1017, 0);
    // R2 wrap modulo 2^64, base is r4 (legal as base)
    req("R2 wrap", 1, 4, 0, 0, 0, 32'h20, 2, 1, 64'h10, 0);
    // R3: omitted base and index
    req("R3 no base", 0, 1, 1, 2, 2, 32'h4, 2, 0, 64'h10, 0);
    req("R3 no index", 1, 1, 0, 4, 3, 32'h0, 2, 0, 64'h1000, 0);
    // R4: upper bits ignored for narrow sizes
    req("R4 byte", 0, 0, 0, 0, 0, 32'hABCD_1280, 0, 0, 64'hFFFF_FFFF_FFFF_FF80, 0);
    req("R4 word", 0, 0, 0, 0, 0, 32'hABCD_7FFF, 1, 0, 64'h7FFF, 0);
    req("R4 dword", 0, 0, 0, 0, 0, 32'h8000_0000, 2, 0, 64'hFFFF_FFFF_8000_0000, 0);
    // R5: index 4 and size code 3 are illegal
    req("R5 idx4", 1, 1, 1, 4, 0, 32'h0, 0, 0, 64'h0, 1);
    chk("R5 no read", 64'(out_mem_rd), 64'd0);
    req("R5 size3", 1, 1, 0, 0, 0, 32'h1, 3, 1, 64'h0, 1);
    chk("R5 no wb", 64'(out_wb), 64'd0);
    // R6: address-only mode
    req("R6 lea", 1, 1, 0, 0, 0, 32'h8, 0, 1, 64'h1008, 0);
    chk("R6 wb", 64'(out_wb), 64'd1);
    chk("R6 dst", 64'(out_dst), 64'd4);

    // R10: write and accept at the same edge read the old value
    @(negedge clk);
    rf_we = 1; rf_waddr = 1; rf_wdata = 64'h5000;
    in_valid = 1; in_base_en = 1; in_base_sel = 1; in_idx_en = 0; in_disp_sz = 2; in_disp = 0;
    @(negedge clk);
    rf_we = 0; in_valid = 0; #2;
    chk("R10 old value", out_addr, 64'h1000);
    req("R10 new value", 1, 1, 0, 0, 0, 32'h0, 2, 0, 64'h5000, 0);

    // R8: stall holds outputs
    @(negedge clk);
    out_ready = 0; in_valid = 1; in_disp = 32'h33; in_base_en = 0;
    @(negedge clk);
    in_disp = 32'h44;
    repeat (3) @(negedge clk);
    #2;
    chk("R8 held addr", out_addr, 64'h33);
    chk("R9 stalled ready", 64'(in_ready), 64'd0);
    out_ready = 1; idle();

    // mixed traffic with back-pressure, compared every cycle
    for (int n = 0; n < 3000; n++) begin
      @(negedge clk);
      in_valid = 1'($urandom); in_base_en = 1'($urandom); in_idx_en = 1'($urandom);
      in_base_sel = 4'($urandom); in_idx_sel = 4'($urandom); in_scale = 2'($urandom);
      in_disp = $urandom; in_disp_sz = 2'($urandom); in_lea = 1'($urandom);
      in_dst = 4'($urandom); out_ready = ($urandom % 4) != 0;
      rf_we = ($urandom % 3) == 0; rf_waddr = 4'($urandom);
      rf_wdata = {$urandom, $urandom};
    end
    @(negedge clk);
    idle(); out_ready = 1;
    repeat (3) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 50000) begin
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected<=50000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule